// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits next to one processor. It holds the interrupt that is presented to that processor, together with the processor's current priority. Each clock cycle it can take one interrupt offer from the source layer, as a source number plus a priority. In the same cycle it can take one processor operation. The operations are: set the priority, write the inter-processor interrupt (IPI) request, accept, end of interrupt (EOI) and poll.

Lower priority values are more favoured. A better offer takes over the pending slot, and the interrupt it displaces is returned to its source. A software IPI request with a better priority also takes the slot. It shows up as source number 2. Because no source owns an IPI, it is never returned.

All state and all outputs are registered. The result of an operation or offer appears in the cycle after the clock edge that samples it. Notifications to the source layer (bounce, resend, EOI) are one-cycle pulses.

Top module: `irq_presenter`

## Requirements
- R1: After reset the presentation word reads 0x00000000, the IPI request reads 0xFF, the pending priority is 0xFF and `irq_out` is low.
- R2: A poll (op code 4) returns the word {processor priority in bits 31:24, pending source in bits 23:0} on `rd_word`, with the IPI request on `rd_ipi`. A poll changes no state and no output line. A source of zero means nothing is pending.
- R3: An offer is bounced on the offer channel, carrying its own source number, when its priority is greater than or equal to the processor priority. It is also bounced when a source is pending at a priority numerically less than or equal to the offer's.
- R4: An offer that is not bounced stores its source and priority and raises `irq_out`. A displaced external source is bounced on the offer channel. `irq_out` is high exactly when the pending source is non-zero.
- R5: Accept (op code 2) returns the word as it was before the operation. It then moves the pending priority into bits 31:24, clears the source, sets the pending priority to 0xFF and lowers `irq_out`.
- R6: Set priority (op code 0, value in `op_data[7:0]`) with a value not below the old one, while nothing is pending, pulses `resend_req`. If the IPI request is then below the processor priority, the IPI check (R9) also runs.
- R7: Set priority with a value below the old one clears a pending source when the new value is less than or equal to the pending priority. It then sets the pending priority to 0xFF, lowers `irq_out` and bounces the source on the operation channel if it was external. Otherwise the pending source is kept.
- R8: Set IPI (op code 1, value in `op_data[7:0]`) stores the request. The IPI check runs only when the value is below the processor priority.
- R9: The IPI check does nothing if a source is pending at a priority less than or equal to the request. Otherwise it bounces any pending external source on the operation channel, loads source 2 at the request priority and raises `irq_out`. An IPI is never bounced.
- R10: EOI (op code 3) copies `op_data[31:24]` into the processor priority and pulses `eoi_valid` with `op_data[23:0]`. If nothing is pending, it performs the resend of R6.
- R11: When an operation and an offer arrive in the same cycle, the operation is applied first and the offer is judged against the result. Each uses its own bounce channel.
- R12: Op codes 5 to 7 change nothing and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Processor operation present |
| op_code | input | 3 | 0 priority, 1 IPI, 2 accept, 3 EOI, 4 poll |
| op_data | input | 32 | Operation operand |
| offer_valid | input | 1 | Source layer offers an interrupt |
| offer_src | input | 24 | Offered source number (non-zero) |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Read result present (accept or poll) |
| rd_word | output | 32 | Presentation word returned |
| rd_ipi | output | 8 | IPI request returned by poll |
| op_bounce_valid | output | 1 | Operation displaced an external source |
| op_bounce_src | output | 24 | Source bounced by the operation |
| offer_bounce_valid | output | 1 | Offer refused or displaced a source |
| offer_bounce_src | output | 24 | Source bounced by the offer path |
| resend_req | output | 1 | Source layer must re-offer its interrupts |
| eoi_valid | output | 1 | EOI forwarded to the source layer |
| eoi_src | output | 24 | Source number of the EOI |

## Verification
A processor operation and a source-layer offer can land in the same cycle, so the ordering rule of R11 is the delicate point. The bench drives the two together in two cases. In the first, a priority raise triggers an IPI through a resend, and the simultaneous offer then silently displaces that IPI. In the second, an IPI write bounces an external source on the operation channel, and the offer is refused on the offer channel in the same cycle. Each result is judged against all outputs in the following cycle.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  parameter int PRIO_W = 8;
  parameter int SRC_W  = 24;
  parameter int WORD_W = PRIO_W + SRC_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [SRC_W-1:0]  src_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam prio_t PRIO_NONE = '1;

  typedef enum logic [2:0] {
    OPC_SET_PRIO = 3'd0,
    OPC_SET_IPI  = 3'd1,
    OPC_ACCEPT   = 3'd2,
    OPC_EOI      = 3'd3,
    OPC_POLL     = 3'd4
  } opcode_e;

  typedef struct packed {
    prio_t cppr;     // processor priority
    src_t  src;      // pending source, zero = none
    prio_t pend;     // priority of the pending source
    prio_t ipi_req;  // software IPI request level
    logic  owned;    // pending source belongs to the source layer
    logic  line;     // interrupt line
  } pres_state_t;

  function automatic word_t pack_word(prio_t cppr, src_t src);
    return {cppr, src};
  endfunction

  function automatic logic offer_refused(prio_t offer, prio_t cppr,
                                         src_t src, prio_t pend);
    return (offer >= cppr) || ((src != '0) && (pend <= offer));
  endfunction

  function automatic logic ipi_blocked(src_t src, prio_t pend, prio_t req);
    return (src != '0) && (pend <= req);
  endfunction

  function automatic logic prio_drop_clears(prio_t newp, src_t src, prio_t pend);
    return (src != '0) && (newp <= pend);
  endfunction
endpackage

// File: rtl/irqp_op_stage.sv
module irqp_op_stage
  import irqp_pkg::*;
#(
  parameter int IPI_SRC_ID = 2
) (
  input  pres_state_t cur,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  word_t       op_data,
  output pres_state_t nxt,
  output logic        bounce_valid,
  output src_t        bounce_src,
  output logic        resend,
  output logic        eoi_valid,
  output src_t        eoi_src,
  output logic        rd_valid,
  output word_t       rd_word,
  output prio_t       rd_ipi,
  output logic        ipi_fired
);
  localparam src_t IPI_SRC = src_t'(IPI_SRC_ID);

  logic  run_check;
  logic  run_resend;
  prio_t arg;

  assign arg = op_data[PRIO_W-1:0];

  always_comb begin
    nxt          = cur;
    bounce_valid = 1'b0;
    bounce_src   = '0;
    resend       = 1'b0;
    eoi_valid    = 1'b0;
    eoi_src      = '0;
    rd_valid     = 1'b0;
    rd_word      = '0;
    rd_ipi       = '0;
    ipi_fired    = 1'b0;
    run_check    = 1'b0;
    run_resend   = 1'b0;

    if (op_valid) begin
      case (opcode_e'(op_code))
        OPC_SET_PRIO: begin
          nxt.cppr = arg;
          if (arg < cur.cppr) begin
            if (prio_drop_clears(arg, cur.src, cur.pend)) begin
              if (cur.owned) begin
                bounce_valid = 1'b1;
                bounce_src   = cur.src;
              end
              nxt.src   = '0;
              nxt.pend  = PRIO_NONE;
              nxt.owned = 1'b0;
              nxt.line  = 1'b0;
            end
          end else if (cur.src == '0) begin
            run_resend = 1'b1;
          end
        end
        OPC_SET_IPI: begin
          nxt.ipi_req = arg;
          if (arg < cur.cppr) run_check = 1'b1;
        end
        OPC_ACCEPT: begin
          rd_valid  = 1'b1;
          rd_word   = pack_word(cur.cppr, cur.src);
          nxt.cppr  = cur.pend;
          nxt.src   = '0;
          nxt.pend  = PRIO_NONE;
          nxt.owned = 1'b0;
          nxt.line  = 1'b0;
        end
        OPC_EOI: begin
          nxt.cppr  = op_data[WORD_W-1:SRC_W];
          eoi_valid = 1'b1;
          eoi_src   = op_data[SRC_W-1:0];
          if (cur.src == '0) run_resend = 1'b1;
        end
        OPC_POLL: begin
          rd_valid = 1'b1;
          rd_word  = pack_word(cur.cppr, cur.src);
          rd_ipi   = cur.ipi_req;
        end
        default: ;
      endcase
    end

    if (run_resend) begin
      resend = 1'b1;
      if (nxt.ipi_req < nxt.cppr) run_check = 1'b1;
    end

    if (run_check && !ipi_blocked(nxt.src, nxt.pend, nxt.ipi_req)) begin
      if ((nxt.src != '0) && nxt.owned) begin
        bounce_valid = 1'b1;
        bounce_src   = nxt.src;
      end
      nxt.src   = IPI_SRC;
      nxt.pend  = nxt.ipi_req;
      nxt.owned = 1'b0;
      nxt.line  = 1'b1;
      ipi_fired = 1'b1;
    end
  end
endmodule

// File: rtl/irqp_offer_stage.sv
module irqp_offer_stage
  import irqp_pkg::*;
(
  input  pres_state_t cur,
  input  logic        offer_valid,
  input  src_t        offer_src,
  input  prio_t       offer_prio,
  output pres_state_t nxt,
  output logic        bounce_valid,
  output src_t        bounce_src,
  output logic        taken
);
  always_comb begin
    nxt          = cur;
    bounce_valid = 1'b0;
    bounce_src   = '0;
    taken        = 1'b0;
    if (offer_valid) begin
      if (offer_refused(offer_prio, cur.cppr, cur.src, cur.pend)) begin
        bounce_valid = 1'b1;
        bounce_src   = offer_src;
      end else begin
        if ((cur.src != '0) && cur.owned) begin
          bounce_valid = 1'b1;
          bounce_src   = cur.src;
        end
        nxt.src   = offer_src;
        nxt.pend  = offer_prio;
        nxt.owned = 1'b1;
        nxt.line  = 1'b1;
        taken     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int IPI_SRC_ID = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] op_data,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              irq_out,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic [PRIO_W-1:0] rd_ipi,
  output logic              op_bounce_valid,
  output logic [SRC_W-1:0]  op_bounce_src,
  output logic              offer_bounce_valid,
  output logic [SRC_W-1:0]  offer_bounce_src,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src
);
  pres_state_t state_q, after_op, after_offer;

  logic  op_bv, of_bv, op_rs, op_ev, op_rv, ipi_fired, offer_took;
  src_t  op_bs, of_bs, op_es;
  word_t op_rw;
  prio_t op_ri;

  // named views of the held state for the checker
  prio_t cur_cppr;
  src_t  cur_src;
  prio_t cur_pend;
  assign cur_cppr = state_q.cppr;
  assign cur_src  = state_q.src;
  assign cur_pend = state_q.pend;

  irqp_op_stage #(.IPI_SRC_ID(IPI_SRC_ID)) u_op (
    .cur(state_q), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .nxt(after_op), .bounce_valid(op_bv), .bounce_src(op_bs), .resend(op_rs),
    .eoi_valid(op_ev), .eoi_src(op_es), .rd_valid(op_rv), .rd_word(op_rw),
    .rd_ipi(op_ri), .ipi_fired(ipi_fired)
  );

  irqp_offer_stage u_offer (
    .cur(after_op), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .nxt(after_offer), .bounce_valid(of_bv),
    .bounce_src(of_bs), .taken(offer_took)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q.cppr       <= '0;
      state_q.src        <= '0;
      state_q.pend       <= PRIO_NONE;
      state_q.ipi_req    <= PRIO_NONE;
      state_q.owned      <= 1'b0;
      state_q.line       <= 1'b0;
      rd_valid           <= 1'b0;
      rd_word            <= '0;
      rd_ipi             <= '0;
      op_bounce_valid    <= 1'b0;
      op_bounce_src      <= '0;
      offer_bounce_valid <= 1'b0;
      offer_bounce_src   <= '0;
      resend_req         <= 1'b0;
      eoi_valid          <= 1'b0;
      eoi_src            <= '0;
    end else begin
      state_q            <= after_offer;
      rd_valid           <= op_rv;
      rd_word            <= op_rw;
      rd_ipi             <= op_ri;
      op_bounce_valid    <= op_bv;
      op_bounce_src      <= op_bs;
      offer_bounce_valid <= of_bv;
      offer_bounce_src   <= of_bs;
      resend_req         <= op_rs;
      eoi_valid          <= op_ev;
      eoi_src            <= op_es;
    end
  end

  assign irq_out = state_q.line;
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker
  import irqp_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  op_valid,
  input logic [2:0] op_code,
  input word_t op_data,
  input logic  offer_valid,
  input src_t  offer_src,
  input prio_t offer_prio,
  input prio_t cur_cppr,
  input src_t  cur_src,
  input prio_t cur_pend,
  input logic  irq_out,
  input logic  rd_valid,
  input word_t rd_word,
  input logic  offer_bounce_valid,
  input src_t  offer_bounce_src,
  input logic  eoi_valid,
  input src_t  eoi_src,
  input logic  ipi_fired,
  input logic  offer_took
);
  a_r4_line_matches_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (cur_src != '0));

  a_r5_empty_slot_least_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_src == '0) |-> (cur_pend == PRIO_NONE));

  a_r5_accept_returns_old: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=>
      (rd_valid && rd_word == $past({cur_cppr, cur_src})));

  a_r3_refuse_weak_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !op_valid && offer_prio >= cur_cppr) |=>
      (offer_bounce_valid && offer_bounce_src == $past(offer_src)));

  a_r10_eoi_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |=>
      (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])));

  a_r9_ipi_raises_line: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_fired |=> irq_out);

  a_r4_taken_raises_line: assert property (@(posedge clk) disable iff (!rst_n)
    offer_took |=> (irq_out && cur_src == $past(offer_src)));
endmodule

bind irq_presenter irqp_checker u_irqp_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_data(op_data), .offer_valid(offer_valid), .offer_src(offer_src),
  .offer_prio(offer_prio), .cur_cppr(cur_cppr), .cur_src(cur_src),
  .cur_pend(cur_pend), .irq_out(irq_out), .rd_valid(rd_valid),
  .rd_word(rd_word), .offer_bounce_valid(offer_bounce_valid),
  .offer_bounce_src(offer_bounce_src), .eoi_valid(eoi_valid),
  .eoi_src(eoi_src), .ipi_fired(ipi_fired), .offer_took(offer_took)
);

// File: tb/test_irq_presenter.sv
module test_irq_presenter;
  localparam logic [2:0] C_PRIO = 3'd0, C_IPI = 3'd1, C_ACC = 3'd2,
                         C_EOI = 3'd3, C_POLL = 3'd4, C_BAD = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        irq_out, rd_valid, op_bounce_valid, offer_bounce_valid;
  logic        resend_req, eoi_valid;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi;
  logic [23:0] op_bounce_src, offer_bounce_src, eoi_src;

  always #2 clk = ~clk;

  irq_presenter i_irq_presenter (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .irq_out(irq_out), .rd_valid(rd_valid),
    .rd_word(rd_word), .rd_ipi(rd_ipi), .op_bounce_valid(op_bounce_valid),
    .op_bounce_src(op_bounce_src), .offer_bounce_valid(offer_bounce_valid),
    .offer_bounce_src(offer_bounce_src), .resend_req(resend_req),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  typedef struct {
    logic        irq;
    logic        rv;
    logic [31:0] rw;
    logic [7:0]  ri;
    logic        bov;
    logic [23:0] bos;
    logic        bfv;
    logic [23:0] bfs;
    logic        rs;
    logic        ev;
    logic [23:0] es;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic timed_out = 1'b0;

  function automatic exp_t quiet(logic irq, string tag);
    exp_t e;
    e.irq = irq; e.rv = 0; e.rw = 0; e.ri = 0; e.bov = 0; e.bos = 0;
    e.bfv = 0; e.bfs = 0; e.rs = 0; e.ev = 0; e.es = 0; e.tag = tag;
    return e;
  endfunction

  // driver: one cycle of stimulus plus the outputs expected after that edge
  task automatic drive(input logic ov, input logic [2:0] code,
                       input logic [31:0] data, input logic fv,
                       input logic [23:0] src, input logic [7:0] prio,
                       input exp_t e);
    @(negedge clk);
    op_valid = ov; op_code = code; op_data = data;
    offer_valid = fv; offer_src = src; offer_prio = prio;
    q.push_back(e);
  endtask

  task automatic op(input logic [2:0] code, input logic [31:0] data, input exp_t e);
    drive(1'b1, code, data, 1'b0, 24'h0, 8'h0, e);
  endtask

  task automatic offer(input logic [23:0] src, input logic [7:0] prio, input exp_t e);
    drive(1'b0, 3'd0, 32'h0, 1'b1, src, prio, e);
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 0; offer_valid = 0;
  endtask

  // monitor: compares right after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (irq_out !== e.irq || rd_valid !== e.rv || rd_word !== e.rw ||
            rd_ipi !== e.ri || op_bounce_valid !== e.bov ||
            op_bounce_src !== e.bos || offer_bounce_valid !== e.bfv ||
            offer_bounce_src !== e.bfs || resend_req !== e.rs ||
            eoi_valid !== e.ev || eoi_src !== e.es) begin
          errors++;
          $display("FAIL %s: got irq=%0b rd=%0b/%h/%h ob=%0b/%h fb=%0b/%h rs=%0b eoi=%0b/%h expected irq=%0b rd=%0b/%h/%h ob=%0b/%h fb=%0b/%h rs=%0b eoi=%0b/%h",
                   e.tag, irq_out, rd_valid, rd_word, rd_ipi, op_bounce_valid,
                   op_bounce_src, offer_bounce_valid, offer_bounce_src,
                   resend_req, eoi_valid, eoi_src, e.irq, e.rv, e.rw, e.ri,
                   e.bov, e.bos, e.bfv, e.bfs, e.rs, e.ev, e.es);
        end
      end
    end
  end

  task automatic run_all();
    exp_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (irq_out !== 1'b0 || rd_valid !== 1'b0 || resend_req !== 1'b0 ||
        op_bounce_valid !== 1'b0 || offer_bounce_valid !== 1'b0 || eoi_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: irq=%0b rd=%0b rs=%0b expected all 0",
               irq_out, rd_valid, resend_req);
    end
    // R1/R2: poll straight after reset
    e = quiet(0, "R1 R2 poll after reset"); e.rv = 1; e.rw = 32'h0; e.ri = 8'hFF;
    op(C_POLL, 0, e);
    // R3: priority 5 not below cppr 0
    e = quiet(0, "R3 refused, prio >= cppr"); e.bfv = 1; e.bfs = 24'h100;
    offer(24'h100, 8'h05, e);
    // R6: raise priority with nothing pending
    e = quiet(0, "R6 resend on raise"); e.rs = 1;
    op(C_PRIO, 32'hFF, e);
    e = quiet(1, "R4 offer taken");
    offer(24'h100, 8'h10, e);
    e = quiet(1, "R3 refused, pending better"); e.bfv = 1; e.bfs = 24'h200;
    offer(24'h200, 8'h20, e);
    e = quiet(1, "R4 displaces external"); e.bfv = 1; e.bfs = 24'h100;
    offer(24'h300, 8'h08, e);
    e = quiet(1, "R2 poll keeps line"); e.rv = 1; e.rw = 32'hFF000300; e.ri = 8'hFF;
    op(C_POLL, 0, e);
    e = quiet(0, "R5 accept"); e.rv = 1; e.rw = 32'hFF000300;
    op(C_ACC, 0, e);
    e = quiet(1, "R8 R9 IPI loaded");
    op(C_IPI, 32'h04, e);
    e = quiet(1, "R9 poll shows IPI"); e.rv = 1; e.rw = 32'h08000002; e.ri = 8'h04;
    op(C_POLL, 0, e);
    e = quiet(1, "R9 IPI displaced silently");
    offer(24'h400, 8'h03, e);
    e = quiet(1, "R9 IPI bounces external"); e.bov = 1; e.bos = 24'h400;
    op(C_IPI, 32'h02, e);
    e = quiet(0, "R7 drop clears IPI without bounce");
    op(C_PRIO, 32'h01, e);
    e = quiet(0, "R7 poll after clear"); e.rv = 1; e.rw = 32'h01000000; e.ri = 8'h02;
    op(C_POLL, 0, e);
    e = quiet(1, "R10 EOI with resend"); e.ev = 1; e.es = 24'h555; e.rs = 1;
    op(C_EOI, 32'h0A000555, e);
    e = quiet(0, "R5 accept IPI"); e.rv = 1; e.rw = 32'h0A000002;
    op(C_ACC, 0, e);
    // R11: resend-triggered IPI then displaced by simultaneous offer
    e = quiet(1, "R11 op then offer, IPI displaced"); e.rs = 1;
    drive(1, C_PRIO, 32'h30, 1, 24'h600, 8'h01, e);
    // R11: both channels in one cycle
    e = quiet(1, "R11 two bounce channels");
    e.bov = 1; e.bos = 24'h600; e.bfv = 1; e.bfs = 24'h700;
    drive(1, C_IPI, 32'h00, 1, 24'h700, 8'h00, e);
    e = quiet(1, "R7 drop above pending keeps it");
    op(C_PRIO, 32'h10, e);
    e = quiet(1, "R8 request not below cppr, no check");
    op(C_IPI, 32'hFF, e);
    e = quiet(1, "R12 unused op code");
    op(C_BAD, 32'hFFFFFFFF, e);
    e = quiet(1, "R12 R8 poll unchanged"); e.rv = 1; e.rw = 32'h10000002; e.ri = 8'hFF;
    op(C_POLL, 0, e);
    e = quiet(0, "R5 accept after drop"); e.rv = 1; e.rw = 32'h10000002;
    op(C_ACC, 0, e);
    e = quiet(0, "R3 equal priority refused"); e.bfv = 1; e.bfs = 24'h800;
    offer(24'h800, 8'h00, e);
    idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule